// File: doc/BRIEF.md
# SMBus Block Process-Call Host Sequencer

This block is the master-side sequencer for the two-part SMBus process call, in which a counted write block and a counted read block travel in one message. Before the call, the host loads the outgoing block into a 32-byte buffer. It then starts the call with the target address, the command code, the write count and a PEC enable. The sequencer works through the whole message by handing single commands to a bit-level bus engine: start, repeated start, stop, write byte and read byte. It stores the returned block in the same buffer, where the host reads it out through a rewindable pointer.

The sequencer never issues a STOP between the two parts. It checks the combined length against the buffer size, and it keeps a CRC-8 over every byte of the message. When PEC is enabled, it compares that CRC with the byte the target returns after the read block. It ends every accepted call with a STOP and a one-cycle done pulse. Three flags report the outcome: a length error, a device error and a PEC error.

Top module: `pcall_seq`

## Requirements
- R1: After `go`, the engine receives START, then WRITE of `{tgt_addr,0}`, WRITE of `cmd_code`, WRITE of `wr_count` (M), then M WRITEs of buffer bytes 0..M-1. Bus command codes on `bus_cmd`: START=0, RSTART=1, STOP=2, WRITE=3, READ=4.
- R2: A write count of 0, or one of 32 or more, is refused at `go`. The block raises `done` and `err_len` on the next cycle and issues no bus command.
- R3: After the last write byte comes RSTART, with no STOP before it, then a WRITE of `{tgt_addr,1}`.
- R4: The first READ returns the read count N, which is shown on `rd_count`. If N is 0, the block sets `err_len`, issues STOP and performs no further READ.
- R5: If M+N is greater than 32, the block sets `err_len` and issues STOP right after the count byte. M+N equal to 32 is accepted.
- R6: The block issues N data READs. With PEC on, one more READ follows for the PEC byte. `bus_nack_out`=1 (NACK) goes with the last READ of the call, and every earlier READ carries 0 (ACK).
- R7: The PEC is CRC-8 with polynomial 0x07 and initial value 0. It covers both address bytes, the command, M, the write data, N and the read data. If the received PEC byte differs from this CRC, `err_pec` is set.
- R8: If the target NACKs (`bus_nack`=1) any address, command, count or write-data byte, the next command is STOP and `err_dev` is set.
- R9: Read byte i is stored at buffer index i. `host_rewind` sets the host pointer to 0. `host_rdata` shows the byte at the pointer, and `host_pop` advances the pointer.
- R10: `busy` is high during a call. `done` pulses for exactly one cycle when the final STOP completes. All error flags clear when a new call starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse (sampled when idle) |
| tgt_addr | input | 7 | Target address |
| cmd_code | input | 8 | Command code |
| wr_count | input | 8 | Write byte count M |
| pec_en | input | 1 | Expect and check a PEC byte |
| host_we | input | 1 | Host buffer write (idle only) |
| host_idx | input | 5 | Host buffer write index |
| host_wdata | input | 8 | Host buffer write data |
| host_rewind | input | 1 | Reset host read pointer to 0 |
| host_pop | input | 1 | Advance host read pointer |
| host_rdata | output | 8 | Buffer byte at host read pointer |
| rd_count | output | 8 | Received read count N |
| busy | output | 1 | Call in progress |
| done | output | 1 | One-cycle completion pulse |
| err_len | output | 1 | Length error |
| err_dev | output | 1 | Target NACK error |
| err_pec | output | 1 | PEC mismatch |
| bus_req | output | 1 | One-cycle command request to bus engine |
| bus_cmd | output | 3 | Bus command code |
| bus_wdata | output | 8 | Byte to write |
| bus_nack_out | output | 1 | Master NACK for this READ |
| bus_done | input | 1 | Engine finished the command |
| bus_rdata | input | 8 | Byte read by the engine |
| bus_nack | input | 1 | Target NACKed the written byte |

## Verification
Most internal faults in this block show up on the bus command stream within one command. A phase or index error changes the order, count or data of the WRITE and READ commands, or it moves the RSTART and STOP. A wrong last-byte decision flips the ACK/NACK bit on a READ. A corrupted PEC accumulator stays hidden until the PEC byte returns at the end of the read part, where it appears as a wrong `err_pec` value. Buffer indexing faults appear only when the host reads the block back.

// File: rtl/pcall_pkg.sv
package pcall_pkg;

  typedef enum logic [2:0] {
    BC_START  = 3'd0,
    BC_RSTART = 3'd1,
    BC_STOP   = 3'd2,
    BC_WRITE  = 3'd3,
    BC_READ   = 3'd4
  } bus_op_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_ADDRW, PH_CMD, PH_WCNT, PH_WDATA,
    PH_RSTART, PH_ADDRR, PH_RCNT, PH_RDATA, PH_RPEC, PH_STOP
  } phase_e;

  // one byte through an MSB-first CRC-8
  function automatic logic [7:0] crc8_step(input logic [7:0] c,
                                           input logic [7:0] d,
                                           input logic [7:0] poly);
    logic [7:0] r;
    r = c ^ d;
    for (int b = 0; b < 8; b++) begin
      r = r[7] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/pcall_crc8.sv
module pcall_crc8 import pcall_pkg::*; #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);

  logic [7:0] crc_d;

  always_comb begin
    crc_d = crc;
    if (clr)     crc_d = 8'h00;
    else if (en) crc_d = crc8_step(crc, din, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= 8'h00;
    else        crc <= crc_d;
  end

  // R7: a cleared accumulator starts from zero
  a_r7_crc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == 8'h00));

endmodule

// File: rtl/pcall_buf.sv
module pcall_buf #(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] ridx,
  output logic [7:0]    rdata,
  input  logic          rewind,
  input  logic          pop,
  output logic [7:0]    hdata
);

  logic [7:0]    mem [DEPTH];
  logic [IW-1:0] ptr_q, ptr_d;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (rewind)   ptr_d = '0;
    else if (pop) ptr_d = ptr_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign rdata = mem[ridx];
  assign hdata = mem[ptr_q];

  // R9: rewind returns the host pointer to the first byte
  a_r9_rewind_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (ptr_q == '0));

endmodule

// File: rtl/pcall_seq.sv
module pcall_seq import pcall_pkg::*; #(
  parameter int BUF_BYTES = 32,
  localparam int IDX_W = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [6:0]       tgt_addr,
  input  logic [7:0]       cmd_code,
  input  logic [7:0]       wr_count,
  input  logic             pec_en,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [7:0]       host_wdata,
  input  logic             host_rewind,
  input  logic             host_pop,
  output logic [7:0]       host_rdata,
  output logic [7:0]       rd_count,
  output logic             busy,
  output logic             done,
  output logic             err_len,
  output logic             err_dev,
  output logic             err_pec,
  output logic             bus_req,
  output logic [2:0]       bus_cmd,
  output logic [7:0]       bus_wdata,
  output logic             bus_nack_out,
  input  logic             bus_done,
  input  logic [7:0]       bus_rdata,
  input  logic             bus_nack
);

  localparam logic [8:0] LIMIT = 9'(BUF_BYTES);

  phase_e           phase_q, phase_d;
  logic             pend_q, pend_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       wcnt_q, wcnt_d, rcnt_q, rcnt_d, cmd_q, cmd_d;
  logic [6:0]       addr_q, addr_d;
  logic             pec_q, pec_d;
  logic             done_q, done_d, elen_q, elen_d, edev_q, edev_d, epec_q, epec_d;

  bus_op_e    op;
  logic [7:0] wdat, buf_rd, crc, crc_din, idx_ext;
  logic       nk_o, is_wr, step, too_long, crc_clr, crc_en, eng_we;
  logic [8:0] sum;

  assign idx_ext  = {{(8-IDX_W){1'b0}}, idx_q};
  assign step     = pend_q && bus_done;
  assign sum      = {1'b0, wcnt_q} + {1'b0, bus_rdata};
  assign too_long = (sum > LIMIT);

  // command presented to the bus engine in each phase
  always_comb begin
    op    = BC_STOP;
    wdat  = 8'h00;
    nk_o  = 1'b0;
    is_wr = 1'b0;
    unique case (phase_q)
      PH_START:  op = BC_START;
      PH_ADDRW:  begin op = BC_WRITE; wdat = {addr_q, 1'b0}; is_wr = 1'b1; end
      PH_CMD:    begin op = BC_WRITE; wdat = cmd_q;          is_wr = 1'b1; end
      PH_WCNT:   begin op = BC_WRITE; wdat = wcnt_q;         is_wr = 1'b1; end
      PH_WDATA:  begin op = BC_WRITE; wdat = buf_rd;         is_wr = 1'b1; end
      PH_RSTART: op = BC_RSTART;
      PH_ADDRR:  begin op = BC_WRITE; wdat = {addr_q, 1'b1}; is_wr = 1'b1; end
      PH_RCNT:   op = BC_READ;
      PH_RDATA:  begin op = BC_READ; nk_o = (idx_ext == rcnt_q - 8'd1) && !pec_q; end
      PH_RPEC:   begin op = BC_READ; nk_o = 1'b1; end
      default:   op = BC_STOP;
    endcase
  end

  assign bus_req      = (phase_q != PH_IDLE) && !pend_q;
  assign bus_cmd      = op;
  assign bus_wdata    = wdat;
  assign bus_nack_out = nk_o;

  assign crc_clr = (phase_q == PH_IDLE) && go;
  assign crc_en  = step && ((is_wr && !bus_nack) || phase_q == PH_RCNT || phase_q == PH_RDATA);
  assign crc_din = is_wr ? wdat : bus_rdata;
  assign eng_we  = step && (phase_q == PH_RDATA);

  pcall_crc8 #(.POLY(8'h07)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(crc_din), .crc(crc)
  );

  pcall_buf #(.DEPTH(BUF_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .we(eng_we || (host_we && phase_q == PH_IDLE)),
    .widx(eng_we ? idx_q : host_idx),
    .wdata(eng_we ? bus_rdata : host_wdata),
    .ridx(idx_q), .rdata(buf_rd),
    .rewind(host_rewind), .pop(host_pop), .hdata(host_rdata)
  );

  // next-state logic
  always_comb begin
    phase_d = phase_q; pend_d = pend_q; idx_d = idx_q;
    wcnt_d = wcnt_q; rcnt_d = rcnt_q; cmd_d = cmd_q; addr_d = addr_q; pec_d = pec_q;
    done_d = 1'b0; elen_d = elen_q; edev_d = edev_q; epec_d = epec_q;
    if (phase_q == PH_IDLE) begin
      if (go) begin
        addr_d = tgt_addr; cmd_d = cmd_code; wcnt_d = wr_count; pec_d = pec_en;
        edev_d = 1'b0; epec_d = 1'b0; rcnt_d = 8'h00;
        if (wr_count == 8'd0 || wr_count >= LIMIT[7:0]) begin
          elen_d = 1'b1; done_d = 1'b1;
        end else begin
          elen_d = 1'b0; phase_d = PH_START;
        end
      end
    end else if (bus_req) begin
      pend_d = 1'b1;
    end else if (step) begin
      pend_d = 1'b0;
      if (is_wr && bus_nack) begin
        edev_d = 1'b1; phase_d = PH_STOP;
      end else begin
        unique case (phase_q)
          PH_START:  phase_d = PH_ADDRW;
          PH_ADDRW:  phase_d = PH_CMD;
          PH_CMD:    phase_d = PH_WCNT;
          PH_WCNT:   begin phase_d = PH_WDATA; idx_d = '0; end
          PH_WDATA:  if (idx_ext == wcnt_q - 8'd1) phase_d = PH_RSTART;
                     else idx_d = idx_q + IDX_W'(1);
          PH_RSTART: phase_d = PH_ADDRR;
          PH_ADDRR:  phase_d = PH_RCNT;
          PH_RCNT: begin
            rcnt_d = bus_rdata;
            idx_d  = '0;
            if (bus_rdata == 8'd0 || too_long) begin
              elen_d = 1'b1; phase_d = PH_STOP;
            end else phase_d = PH_RDATA;
          end
          PH_RDATA:  if (idx_ext == rcnt_q - 8'd1) phase_d = pec_q ? PH_RPEC : PH_STOP;
                     else idx_d = idx_q + IDX_W'(1);
          PH_RPEC:   begin epec_d = (bus_rdata != crc); phase_d = PH_STOP; end
          PH_STOP:   begin phase_d = PH_IDLE; done_d = 1'b1; end
          default:   phase_d = PH_IDLE;
        endcase
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE; pend_q <= 1'b0; idx_q <= '0;
      wcnt_q <= 8'h00; rcnt_q <= 8'h00; cmd_q <= 8'h00; addr_q <= 7'h00; pec_q <= 1'b0;
      done_q <= 1'b0; elen_q <= 1'b0; edev_q <= 1'b0; epec_q <= 1'b0;
    end else begin
      phase_q <= phase_d; pend_q <= pend_d; idx_q <= idx_d;
      wcnt_q <= wcnt_d; rcnt_q <= rcnt_d; cmd_q <= cmd_d; addr_q <= addr_d; pec_q <= pec_d;
      done_q <= done_d; elen_q <= elen_d; edev_q <= edev_d; epec_q <= epec_d;
    end
  end

  assign busy     = (phase_q != PH_IDLE);
  assign done     = done_q;
  assign err_len  = elen_q;
  assign err_dev  = edev_q;
  assign err_pec  = epec_q;
  assign rd_count = rcnt_q;

  // R2: an unusable write count ends the call at once with no bus request
  a_r2_reject_count: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && go && (wr_count == 8'd0 || wr_count >= LIMIT[7:0]))
      |=> (done && err_len && !bus_req));

  // R8: a target NACK on a written byte leads straight to STOP
  a_r8_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_wr && bus_nack) |=> (bus_req && bus_cmd == BC_STOP && err_dev));

  // R5: data reads only happen inside the shared payload limit
  a_r5_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RDATA) |-> (({1'b0, wcnt_q} + {1'b0, rcnt_q}) <= LIMIT));

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: each command request lasts exactly one cycle
  a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> !bus_req);

  // R3: the bus is turned around only on an error-free call
  a_r3_rstart_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == BC_RSTART) |-> (!err_len && !err_dev));

endmodule

// File: tb/test_pcall_seq.sv
module test_pcall_seq;
  localparam int CLK_P = 10;
  localparam logic [2:0] C_ST = 3'd0, C_RS = 3'd1, C_SP = 3'd2, C_WR = 3'd3, C_RD = 3'd4;

  logic clk, rst_n;
  logic go, pec_en, host_we, host_rewind, host_pop;
  logic [6:0] tgt_addr;
  logic [7:0] cmd_code, wr_count, host_wdata;
  logic [4:0] host_idx;
  logic [7:0] host_rdata, rd_count, bus_wdata, bus_rdata;
  logic busy, done, err_len, err_dev, err_pec, bus_req, bus_nack_out, bus_done, bus_nack;
  logic [2:0] bus_cmd;

  pcall_seq i_pcall_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .tgt_addr(tgt_addr), .cmd_code(cmd_code),
    .wr_count(wr_count), .pec_en(pec_en), .host_we(host_we), .host_idx(host_idx),
    .host_wdata(host_wdata), .host_rewind(host_rewind), .host_pop(host_pop),
    .host_rdata(host_rdata), .rd_count(rd_count), .busy(busy), .done(done),
    .err_len(err_len), .err_dev(err_dev), .err_pec(err_pec), .bus_req(bus_req),
    .bus_cmd(bus_cmd), .bus_wdata(bus_wdata), .bus_nack_out(bus_nack_out),
    .bus_done(bus_done), .bus_rdata(bus_rdata), .bus_nack(bus_nack)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // target model state
  logic [7:0] wblk [0:31];
  logic [7:0] rsp  [0:40];
  int rsp_i, nack_at, wr_seen;
  logic [2:0] lg_cmd [0:79];
  logic [7:0] lg_dat [0:79];
  logic       lg_nk  [0:79];
  int n_ev;
  logic [2:0] e_cmd [0:79];
  logic [7:0] e_dat [0:79];
  logic       e_nk  [0:79];
  int e_n;

  // bus engine model: answers one negedge after a request
  initial begin
    bus_done = 1'b0; bus_rdata = 8'h00; bus_nack = 1'b0;
    forever begin
      @(negedge clk);
      bus_done = 1'b0; bus_nack = 1'b0;
      if (rst_n && bus_req) begin
        if (n_ev < 80) begin
          lg_cmd[n_ev] = bus_cmd;
          lg_dat[n_ev] = (bus_cmd == C_WR) ? bus_wdata : 8'h00;
          lg_nk[n_ev]  = bus_nack_out;
        end
        n_ev++;
        @(negedge clk);
        bus_done  = 1'b1;
        bus_rdata = 8'h00;
        if (bus_cmd == C_WR) begin
          bus_nack = (wr_seen == nack_at);
          wr_seen++;
        end else if (bus_cmd == C_RD) begin
          bus_rdata = rsp[rsp_i];
          rsp_i++;
        end
      end
    end
  end

  function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int b = 0; b < 8; b++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  function automatic logic [7:0] pec_of(input logic [6:0] a, input logic [7:0] c, input int m, input int n);
    logic [7:0] r;
    r = crc_b(8'h00, {a, 1'b0});
    r = crc_b(r, c);
    r = crc_b(r, 8'(m));
    for (int i = 0; i < m; i++) r = crc_b(r, wblk[i]);
    r = crc_b(r, {a, 1'b1});
    r = crc_b(r, 8'(n));
    for (int i = 0; i < n; i++) r = crc_b(r, rsp[1+i]);
    return r;
  endfunction

  task automatic push(input logic [2:0] c, input logic [7:0] d, input logic k);
    e_cmd[e_n] = c; e_dat[e_n] = d; e_nk[e_n] = k; e_n++;
  endtask

  task automatic build(input logic [6:0] a, input logic [7:0] c, input int m, input int n,
                       input bit pec, input bit len_abort);
    e_n = 0;
    push(C_ST, 8'h00, 1'b0);
    push(C_WR, {a, 1'b0}, 1'b0);
    push(C_WR, c, 1'b0);
    push(C_WR, 8'(m), 1'b0);
    for (int i = 0; i < m; i++) push(C_WR, wblk[i], 1'b0);
    push(C_RS, 8'h00, 1'b0);
    push(C_WR, {a, 1'b1}, 1'b0);
    push(C_RD, 8'h00, 1'b0);
    if (!len_abort) begin
      for (int i = 0; i < n; i++) push(C_RD, 8'h00, (i == n-1) && !pec);
      if (pec) push(C_RD, 8'h00, 1'b1);
    end
    push(C_SP, 8'h00, 1'b0);
  endtask

  task automatic cmp_frame(input string req);
    int mism;
    mism = 0;
    chk(req, "command count", n_ev, e_n);
    for (int i = 0; i < e_n && i < n_ev; i++) begin
      if (lg_cmd[i] !== e_cmd[i] || lg_dat[i] !== e_dat[i] || lg_nk[i] !== e_nk[i]) begin
        if (mism == 0)
          $display("  first difference at command %0d: cmd %0d/%0d data %0h/%0h nack %0b/%0b",
                   i, lg_cmd[i], e_cmd[i], lg_dat[i], e_dat[i], lg_nk[i], e_nk[i]);
        mism++;
      end
    end
    chk(req, "mismatching commands", mism, 0);
  endtask

  task automatic run(input logic [6:0] a, input logic [7:0] c, input int m, input bit pec, input int nk);
    int t;
    bit saw_busy;
    for (int i = 0; i < m && i < 32; i++) begin
      @(negedge clk);
      host_we = 1'b1; host_idx = 5'(i); host_wdata = wblk[i];
    end
    @(negedge clk);
    host_we = 1'b0;
    n_ev = 0; rsp_i = 0; wr_seen = 0; nack_at = nk;
    tgt_addr = a; cmd_code = c; wr_count = 8'(m); pec_en = pec; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    t = 0; saw_busy = 0;
    while (!done && t < 3000) begin
      if (busy) saw_busy = 1;
      @(negedge clk);
      t++;
    end
    chk("R10", "done reached", done, 1'b1);
    if (m >= 1 && m < 32) chk("R10", "busy during call", saw_busy, 1'b1);
    @(negedge clk);
    chk("R10", "done one cycle", done, 1'b0);
    chk("R10", "idle after call", busy, 1'b0);
  endtask

  task automatic t_reset;
    chk("R10", "reset busy", busy, 1'b0);
    chk("R10", "reset done", done, 1'b0);
    chk("R10", "reset errors", {err_len, err_dev, err_pec}, 3'b000);
    chk("R1", "reset bus_req", bus_req, 1'b0);
  endtask

  task automatic set_read(input int n, input logic [7:0] base, input bit bad_pec,
                          input logic [6:0] a, input logic [7:0] c, input int m);
    rsp[0] = 8'(n);
    for (int i = 0; i < n; i++) rsp[1+i] = base + 8'(i * 17);
    rsp[n+1] = pec_of(a, c, m, n) ^ (bad_pec ? 8'h01 : 8'h00);
  endtask

  task automatic t_normal;
    wblk[0] = 8'h11; wblk[1] = 8'h22; wblk[2] = 8'h33;
    set_read(4, 8'hA1, 0, 7'h2A, 8'h5C, 3);
    run(7'h2A, 8'h5C, 3, 1, -1);
    build(7'h2A, 8'h5C, 3, 4, 1, 0);
    cmp_frame("R1 R3 R6");
    chk("R4", "rd_count", rd_count, 8'd4);
    chk("R7", "good PEC", err_pec, 1'b0);
    chk("R5", "no length error", err_len, 1'b0);
    chk("R8", "no device error", err_dev, 1'b0);
  endtask

  task automatic t_readback;
    @(negedge clk); host_rewind = 1'b1;
    @(negedge clk); host_rewind = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R9", "read byte", host_rdata, rsp[1+i]);
      host_pop = 1'b1;
      @(negedge clk);
      host_pop = 1'b0;
    end
    @(negedge clk); host_rewind = 1'b1;
    @(negedge clk); host_rewind = 1'b0;
    chk("R9", "after rewind", host_rdata, rsp[1]);
  endtask

  task automatic t_bad_pec;
    set_read(4, 8'h05, 1, 7'h2A, 8'h5C, 3);
    run(7'h2A, 8'h5C, 3, 1, -1);
    chk("R7", "PEC mismatch flagged", err_pec, 1'b1);
    set_read(2, 8'h70, 0, 7'h13, 8'h01, 3);
    run(7'h13, 8'h01, 3, 1, -1);
    chk("R7", "PEC good after bad", err_pec, 1'b0);
    chk("R10", "flags cleared on new call", {err_len, err_dev}, 2'b00);
  endtask

  task automatic t_no_pec;
    set_read(2, 8'h3C, 0, 7'h51, 8'h9E, 3);
    run(7'h51, 8'h9E, 3, 0, -1);
    build(7'h51, 8'h9E, 3, 2, 0, 0);
    cmp_frame("R6");
    chk("R7", "no PEC no error", err_pec, 1'b0);
  endtask

  task automatic t_zero_m;
    run(7'h10, 8'h22, 0, 1, -1);
    chk("R2", "zero count err_len", err_len, 1'b1);
    chk("R2", "zero count no bus", n_ev, 0);
    run(7'h10, 8'h22, 32, 1, -1);
    chk("R2", "count 32 err_len", err_len, 1'b1);
    chk("R2", "count 32 no bus", n_ev, 0);
  endtask

  task automatic t_limits;
    for (int i = 0; i < 32; i++) wblk[i] = 8'h40 + 8'(i);
    set_read(3, 8'h01, 0, 7'h33, 8'h44, 30);
    run(7'h33, 8'h44, 30, 1, -1);
    build(7'h33, 8'h44, 30, 3, 1, 1);
    cmp_frame("R5");
    chk("R5", "sum 33 err_len", err_len, 1'b1);
    set_read(4, 8'h90, 0, 7'h33, 8'h44, 28);
    run(7'h33, 8'h44, 28, 1, -1);
    build(7'h33, 8'h44, 28, 4, 1, 0);
    cmp_frame("R5");
    chk("R5", "sum 32 accepted", err_len, 1'b0);
    chk("R7", "sum 32 PEC", err_pec, 1'b0);
  endtask

  task automatic t_zero_n;
    wblk[0] = 8'hEE;
    set_read(0, 8'h00, 0, 7'h0F, 8'h0F, 1);
    run(7'h0F, 8'h0F, 1, 1, -1);
    build(7'h0F, 8'h0F, 1, 0, 1, 1);
    cmp_frame("R4");
    chk("R4", "N zero err_len", err_len, 1'b1);
  endtask

  task automatic t_dev_nack;
    wblk[0] = 8'h01; wblk[1] = 8'h02;
    set_read(2, 8'h00, 0, 7'h77, 8'hC3, 2);
    run(7'h77, 8'hC3, 2, 1, 1);
    e_n = 0;
    push(C_ST, 8'h00, 1'b0);
    push(C_WR, {7'h77, 1'b0}, 1'b0);
    push(C_WR, 8'hC3, 1'b0);
    push(C_SP, 8'h00, 1'b0);
    cmp_frame("R8");
    chk("R8", "err_dev on NACK", err_dev, 1'b1);
    chk("R8", "no length error", err_len, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; go = 1'b0; pec_en = 1'b0; host_we = 1'b0; host_rewind = 1'b0; host_pop = 1'b0;
    tgt_addr = '0; cmd_code = '0; wr_count = '0; host_wdata = '0; host_idx = '0;
    n_ev = 0; rsp_i = 0; nack_at = -1; wr_seen = 0; e_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_normal();
    t_readback();
    t_bad_pec();
    t_no_pec();
    t_zero_m();
    t_limits();
    t_zero_n();
    t_dev_nack();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule